// File: doc/BRIEF.md
# Fail-Soft Interleaved Store Mapper

This block presents a 64-bit-wide logical memory. It builds that memory from a set of 36-bit store banks. Each bank word carries 32 data bits and 4 parity bits. When every populated bank is healthy, the banks work in pairs. The low 32 bits of a logical word sit in the even bank of a pair and the high 32 bits in the odd bank at the same bank address. One access cycle therefore moves the full 64 bits.

A per-bank failure mask switches the block into a degraded mode at run time. In that mode the healthy banks are chained in ascending index order. Each logical word occupies two consecutive 32-bit cells of that chain. Every access then costs two single-bank cycles, low half first. The usable logical capacity drops to half a bank depth per healthy bank. When every bank is failed, each request is refused. Contents written in one mode are not relocated when the mode changes.

Each byte gets an odd parity bit on write, and the parity is checked on read. The banks are behavioural arrays. A cell that has not been written since reset reads back as an all-zero 36-bit word. The bank depth is a parameter: a production build uses `BANK_AW = 17`, while the default is kept small for elaboration.

Top module: `fsmap_top`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, `ready_o` is 1 and `rsp_valid_o`, `degraded_o`, `perr_o` are 0.
- R2: With no bank failed, a request accepted in cycle T (`req_i` and `ready_o` high) gets `rsp_valid_o` in cycle T+1. Word `a` keeps bits [31:0] in bank 2*(a/DEPTH) and bits [63:32] in bank 2*(a/DEPTH)+1, both at bank address a mod DEPTH. A new request can be accepted every cycle.
- R3: With some but not all banks failed, `ready_o` is 0 in cycle T+1 after an accept in cycle T, and the response appears in cycle T+2.
- R4: In degraded mode, the healthy banks in ascending index order form slots 0..k-1. Half h (0 = bits [31:0]) of word `a` sits at linear position p = 2a+h, in slot p/DEPTH, at bank address p mod DEPTH.
- R5: In degraded mode, a request with 2a >= k*DEPTH is refused. The refusal is `rsp_valid_o` with `rsp_err_o` = 1 in cycle T+1, with `rdata_o` = 0 and `perr_o` = 0, and no bank is written.
- R6: When every bank is failed, every request is refused in the same way as in R5.
- R7: Parity bit i of a stored half is the odd parity of data byte i of that half (bit 32+i of the bank word). A read response has `perr_o` = 1 when any stored parity bit disagrees, and 0 for data written through the block.
- R8: A cell not written since reset holds all zeros. Reading it gives 0 data for that half and `perr_o` = 1.
- R9: `fail_mask_i` is registered only at clock edges where `ready_o` is high. A request uses the value registered at an earlier edge. A mask value present only while `ready_o` is low has no effect.
- R10: `degraded_o` is 1 exactly when the registered mask has any bit set.
- R11: A write response has `rsp_err_o` = 0, `rdata_o` = 0 and `perr_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fail_mask_i | input | NBANK | One bit per bank, 1 marks the bank failed |
| req_i | input | 1 | Access request, taken when `ready_o` is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | LAW | Logical 64-bit word address |
| wdata_i | input | 64 | Write data |
| ready_o | output | 1 | Block can accept a request this cycle |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_err_o | output | 1 | Request was refused |
| rdata_o | output | 64 | Read data, 0 for writes and refusals |
| perr_o | output | 1 | Parity mismatch in read data |
| degraded_o | output | 1 | Registered failure mask is non-zero |

## Verification
The assertions assume that `req_i` is raised only in cycles where `ready_o` is high. The bench model decides acceptance from its own view of readiness and issues no request during the busy cycle of a degraded access. The assertions also rely on `fail_mask_i` being a plain level input that may change in any cycle. The stimulus changes the mask both in idle cycles and inside the busy cycle, so the point at which the mask is registered can be checked against the requirements.

// File: rtl/fsmap_pkg.sv
package fsmap_pkg;
  localparam int HALF_W = 32;
  localparam int PAR_W  = HALF_W / 8;
  localparam int CELL_W = HALF_W + PAR_W;

  typedef logic [CELL_W-1:0] cell_t;

  typedef enum logic {
    ST_IDLE,
    ST_HI
  } fsm_e;
endpackage

// File: rtl/fsmap_par.sv
module fsmap_par #(
  parameter int NBYTE = 4
) (
  input  logic [8*NBYTE-1:0] data_i,
  output logic [NBYTE-1:0]   par_o
);
  for (genvar g = 0; g < NBYTE; g++) begin : g_byte
    assign par_o[g] = ~^data_i[8*g +: 8];  // odd parity
  end
endmodule

// File: rtl/fsmap_bank.sv
module fsmap_bank
  import fsmap_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  cell_t         wdata_i,
  output cell_t         rdata_o
);
  localparam int DEPTH = 1 << AW;

  cell_t            mem [DEPTH];
  logic [DEPTH-1:0] vld_q;
  cell_t            rd_q;

  always_ff @(posedge clk_i) begin
    if (en_i && we_i) mem[addr_i] <= wdata_i;
  end

  // unwritten cells read as zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      rd_q  <= '0;
    end else if (en_i) begin
      if (we_i) vld_q[addr_i] <= 1'b1;
      else      rd_q <= vld_q[addr_i] ? mem[addr_i] : '0;
    end
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/fsmap_ctrl.sv
module fsmap_ctrl
  import fsmap_pkg::*;
#(
  parameter int NBANK   = 2,
  parameter int BANK_AW = 8,
  localparam int BIDX_W = $clog2(NBANK),
  localparam int LAW    = BANK_AW + BIDX_W - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NBANK-1:0]   fail_mask_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [LAW-1:0]     addr_i,
  output logic               ready_o,
  output logic               degraded_o,
  output logic [NBANK-1:0]   bank_en_o,
  output logic               bank_we_o,
  output logic [BANK_AW-1:0] bank_addr_o,
  output logic [NBANK-1:0]   bank_hi_o,
  output logic               cap_lo_o,
  output logic               hold_sel_o,
  output logic [BIDX_W-1:0]  lo_bank_o,
  output logic [BIDX_W-1:0]  hi_bank_o,
  output logic               rsp_valid_o,
  output logic               rsp_err_o,
  output logic               rsp_rd_o
);
  fsm_e               state_q;
  logic [NBANK-1:0]   mask_q;
  logic [BANK_AW-1:0] hi_addr_q;
  logic [BIDX_W-1:0]  lo_bank_q, hi_bank_q;
  logic               we_q, rsp_q, err_q, rd_q, hold_q, cap_q;

  logic [BIDX_W-1:0]  slot_bank [NBANK];
  int                 n_ok;
  logic               full, all_fail, in_range, refuse, acc;
  logic [LAW:0]       pos;
  logic [BIDX_W-1:0]  slot, fs_bank, pair_lo, pair_hi;
  logic [BANK_AW-1:0] fs_addr;

  // healthy banks, ascending, packed into slots
  always_comb begin
    n_ok = 0;
    for (int b = 0; b < NBANK; b++) slot_bank[b] = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (!mask_q[b]) begin
        slot_bank[n_ok] = BIDX_W'(b);
        n_ok = n_ok + 1;
      end
    end
  end

  assign full     = (mask_q == '0);
  assign all_fail = &mask_q;
  assign pos      = {addr_i, 1'b0};
  assign slot     = pos[LAW:BANK_AW];
  assign fs_addr  = pos[BANK_AW-1:0];
  assign fs_bank  = slot_bank[slot];
  assign in_range = int'(slot) < n_ok;
  assign pair_lo  = BIDX_W'(2 * (int'(addr_i) >> BANK_AW));
  assign pair_hi  = pair_lo + BIDX_W'(1);
  assign refuse   = all_fail || (!full && !in_range);
  assign acc      = req_i && (state_q == ST_IDLE);

  always_comb begin
    bank_en_o   = '0;
    bank_hi_o   = '0;
    bank_addr_o = '0;
    bank_we_o   = we_i;
    if (state_q == ST_HI) begin
      bank_we_o            = we_q;
      bank_en_o[hi_bank_q] = 1'b1;
      bank_hi_o[hi_bank_q] = 1'b1;
      bank_addr_o          = hi_addr_q;
    end else if (acc && !refuse) begin
      if (full) begin
        bank_en_o[pair_lo] = 1'b1;
        bank_en_o[pair_hi] = 1'b1;
        bank_hi_o[pair_hi] = 1'b1;
        bank_addr_o        = addr_i[BANK_AW-1:0];
      end else begin
        bank_en_o[fs_bank] = 1'b1;
        bank_addr_o        = fs_addr;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      mask_q    <= '0;
      hi_addr_q <= '0;
      lo_bank_q <= '0;
      hi_bank_q <= '0;
      we_q      <= 1'b0;
      rsp_q     <= 1'b0;
      err_q     <= 1'b0;
      rd_q      <= 1'b0;
      hold_q    <= 1'b0;
      cap_q     <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      cap_q <= 1'b0;
      if (state_q == ST_HI) begin
        state_q <= ST_IDLE;
        rsp_q   <= 1'b1;
      end else begin
        mask_q <= fail_mask_i;  // mode only moves between accesses
        if (acc) begin
          we_q <= we_i;
          if (refuse) begin
            rsp_q  <= 1'b1;
            err_q  <= 1'b1;
            rd_q   <= 1'b0;
            hold_q <= 1'b0;
          end else if (full) begin
            rsp_q     <= 1'b1;
            err_q     <= 1'b0;
            rd_q      <= !we_i;
            hold_q    <= 1'b0;
            lo_bank_q <= pair_lo;
            hi_bank_q <= pair_hi;
          end else begin
            state_q   <= ST_HI;
            err_q     <= 1'b0;
            rd_q      <= !we_i;
            hold_q    <= 1'b1;
            cap_q     <= !we_i;
            lo_bank_q <= fs_bank;
            hi_bank_q <= fs_bank;
            hi_addr_q <= {fs_addr[BANK_AW-1:1], 1'b1};
          end
        end
      end
    end
  end

  assign ready_o     = (state_q == ST_IDLE);
  assign degraded_o  = |mask_q;
  assign cap_lo_o    = cap_q;
  assign hold_sel_o  = hold_q;
  assign lo_bank_o   = lo_bank_q;
  assign hi_bank_o   = hi_bank_q;
  assign rsp_valid_o = rsp_q;
  assign rsp_err_o   = err_q;
  assign rsp_rd_o    = rd_q;
endmodule

// File: rtl/fsmap_top.sv
module fsmap_top
  import fsmap_pkg::*;
#(
  parameter int NBANK   = 2,
  parameter int BANK_AW = 8,
  localparam int BIDX_W = $clog2(NBANK),
  localparam int LAW    = BANK_AW + BIDX_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NBANK-1:0] fail_mask_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [LAW-1:0]   addr_i,
  input  logic [63:0]      wdata_i,
  output logic             ready_o,
  output logic             rsp_valid_o,
  output logic             rsp_err_o,
  output logic [63:0]      rdata_o,
  output logic             perr_o,
  output logic             degraded_o
);
  logic [NBANK-1:0]   bank_en, bank_hi;
  logic               bank_we;
  logic [BANK_AW-1:0] bank_addr;
  logic               cap_lo, hold_sel, rsp_rd;
  logic [BIDX_W-1:0]  lo_bank, hi_bank;

  fsmap_ctrl #(.NBANK(NBANK), .BANK_AW(BANK_AW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fail_mask_i (fail_mask_i),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .ready_o     (ready_o),
    .degraded_o  (degraded_o),
    .bank_en_o   (bank_en),
    .bank_we_o   (bank_we),
    .bank_addr_o (bank_addr),
    .bank_hi_o   (bank_hi),
    .cap_lo_o    (cap_lo),
    .hold_sel_o  (hold_sel),
    .lo_bank_o   (lo_bank),
    .hi_bank_o   (hi_bank),
    .rsp_valid_o (rsp_valid_o),
    .rsp_err_o   (rsp_err_o),
    .rsp_rd_o    (rsp_rd)
  );

  // write path: high half is replayed from a latch in the busy cycle
  logic [HALF_W-1:0] whi_q, hi_src;
  logic [PAR_W-1:0]  wpar_lo, wpar_hi;
  cell_t             wcell_lo, wcell_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                whi_q <= '0;
    else if (ready_o && req_i)  whi_q <= wdata_i[63:32];
  end

  assign hi_src = ready_o ? wdata_i[63:32] : whi_q;

  fsmap_par #(.NBYTE(PAR_W)) u_wpar_lo (.data_i(wdata_i[31:0]), .par_o(wpar_lo));
  fsmap_par #(.NBYTE(PAR_W)) u_wpar_hi (.data_i(hi_src),        .par_o(wpar_hi));

  assign wcell_lo = {wpar_lo, wdata_i[31:0]};
  assign wcell_hi = {wpar_hi, hi_src};

  cell_t brd [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    fsmap_bank #(.AW(BANK_AW)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (bank_en[b]),
      .we_i    (bank_we),
      .addr_i  (bank_addr),
      .wdata_i (bank_hi[b] ? wcell_hi : wcell_lo),
      .rdata_o (brd[b])
    );
  end

  // read path
  cell_t            hold_q, rd_lo, rd_hi;
  logic [PAR_W-1:0] cpar_lo, cpar_hi;
  logic             rd_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= '0;
    else if (cap_lo) hold_q <= brd[lo_bank];
  end

  assign rd_lo = hold_sel ? hold_q : brd[lo_bank];
  assign rd_hi = brd[hi_bank];

  fsmap_par #(.NBYTE(PAR_W)) u_cpar_lo (.data_i(rd_lo[HALF_W-1:0]), .par_o(cpar_lo));
  fsmap_par #(.NBYTE(PAR_W)) u_cpar_hi (.data_i(rd_hi[HALF_W-1:0]), .par_o(cpar_hi));

  assign rd_ok   = rsp_valid_o && rsp_rd;
  assign rdata_o = rd_ok ? {rd_hi[HALF_W-1:0], rd_lo[HALF_W-1:0]} : '0;
  assign perr_o  = rd_ok && ((cpar_lo != rd_lo[CELL_W-1:HALF_W]) ||
                             (cpar_hi != rd_hi[CELL_W-1:HALF_W]));
endmodule

// File: rtl/fsmap_checker.sv
module fsmap_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        ready_o,
  input logic        rsp_valid_o,
  input logic        rsp_err_o,
  input logic [63:0] rdata_o,
  input logic        perr_o,
  input logic        degraded_o
);
  assert_busy_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ready_o);

  assert_busy_from_accept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> $past(ready_o && req_i));

  assert_rsp_origin_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($past(ready_o && req_i) || $past(!ready_o)));

  assert_refuse_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> (rdata_o == '0 && !perr_o));

  assert_mode_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(degraded_o));

  assert_quiet_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (rdata_o == '0 && !perr_o));
endmodule

bind fsmap_top fsmap_checker u_fsmap_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ready_o     (ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_err_o   (rsp_err_o),
  .rdata_o     (rdata_o),
  .perr_o      (perr_o),
  .degraded_o  (degraded_o)
);

// File: tb/sim_fsmap_top.sv
module sim_fsmap_top;
  localparam int NB  = 2;
  localparam int AW  = 8;
  localparam int DEP = 1 << AW;
  localparam int LAW = AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] mask = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [LAW-1:0] addr = '0;
  logic [63:0]   wdata = '0;
  logic          ready, rsp_valid, rsp_err, perr, degraded;
  logic [63:0]   rdata;

  always #4 clk = ~clk;  // 125 MHz

  fsmap_top #(.NBANK(NB), .BANK_AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fail_mask_i(mask), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .ready_o(ready), .rsp_valid_o(rsp_valid),
    .rsp_err_o(rsp_err), .rdata_o(rdata), .perr_o(perr), .degraded_o(degraded)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  // behavioural reference state
  logic [31:0]   mem_m [int];
  logic [NB-1:0] mask_m = '0;
  bit            busy_m = 0;
  bit            e_v [3], e_err [3], e_per [3];
  logic [63:0]   e_dat [3];
  string         e_tag [3];

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic model_accept(bit w, int a, logic [63:0] d, string tag, output bit slow);
    int hl[$];
    int k, bank, ba, pos, key;
    bit refuse, pe;
    logic [63:0] rd;
    for (int b = 0; b < NB; b++) if (!mask_m[b]) hl.push_back(b);
    k = hl.size();
    refuse = (k == 0) || (k < NB && 2 * a >= k * DEP);
    slow = !refuse && k < NB;
    rd = '0;
    pe = 0;
    if (!refuse) begin
      for (int h = 0; h < 2; h++) begin
        if (k == NB) begin
          bank = 2 * (a / DEP) + h;
          ba = a % DEP;
        end else begin
          pos = 2 * a + h;
          bank = hl[pos / DEP];
          ba = pos % DEP;
        end
        key = bank * DEP + ba;
        if (w) mem_m[key] = d[32*h +: 32];
        else if (mem_m.exists(key)) rd[32*h +: 32] = mem_m[key];
        else pe = 1;
      end
    end
    e_v[slow ? 1 : 0]   = 1;
    e_err[slow ? 1 : 0] = refuse;
    e_dat[slow ? 1 : 0] = (refuse || w) ? 64'h0 : rd;
    e_per[slow ? 1 : 0] = !refuse && !w && pe;
    e_tag[slow ? 1 : 0] = tag;
  endtask

  task automatic step(bit rq, bit w, int a, logic [63:0] d, logic [NB-1:0] m, string tag);
    bit acc, slow;
    @(negedge clk);
    chk("R3", "ready_o", 64'(ready), 64'(!busy_m));
    chk(e_v[0] ? e_tag[0] : "R2", "rsp_valid_o", 64'(rsp_valid), 64'(e_v[0]));
    if (e_v[0]) begin
      chk(e_tag[0], "rsp_err_o", 64'(rsp_err), 64'(e_err[0]));
      chk(e_tag[0], "rdata_o", rdata, e_dat[0]);
      chk(e_tag[0], "perr_o", 64'(perr), 64'(e_per[0]));
    end
    chk("R10", "degraded_o", 64'(degraded), 64'(mask_m != '0));
    acc = rq && !busy_m;
    req = acc;
    we = w;
    addr = LAW'(a);
    wdata = d;
    mask = m;
    for (int i = 0; i < 2; i++) begin
      e_v[i] = e_v[i+1]; e_err[i] = e_err[i+1]; e_dat[i] = e_dat[i+1];
      e_per[i] = e_per[i+1]; e_tag[i] = e_tag[i+1];
    end
    e_v[2] = 0;
    slow = 0;
    if (acc) model_accept(w, a, d, tag, slow);
    if (!busy_m) mask_m = m;
    busy_m = acc && slow;
  endtask

  task automatic access(bit w, int a, logic [63:0] d, logic [NB-1:0] m, string tag);
    while (busy_m) step(0, 0, 0, 64'h0, m, tag);
    step(1, w, a, d, m, tag);
  endtask

  task automatic idle(int n, logic [NB-1:0] m);
    for (int i = 0; i < n; i++) step(0, 0, 0, 64'h0, m, "R10");
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin e_v[i] = 0; e_tag[i] = "R2"; end
    repeat (3) @(negedge clk);
    chk("R1", "ready_o in reset", 64'(ready), 64'h1);
    chk("R1", "rsp_valid_o in reset", 64'(rsp_valid), 64'h0);
    chk("R1", "degraded_o in reset", 64'(degraded), 64'h0);
    chk("R1", "perr_o in reset", 64'(perr), 64'h0);
    rst_n = 1'b1;
    idle(2, 2'b00);

    // normal mode, paired banks
    access(1, 5, 64'h0123_4567_89ab_cdef, 2'b00, "R11");
    access(1, 200, 64'hdead_beef_cafe_f00d, 2'b00, "R11");
    for (int i = 0; i < 8; i++) access(1, 16 + i, {32'(i), 32'hface_0000 + 32'(i)}, 2'b00, "R11");
    for (int i = 0; i < 8; i++) access(0, 16 + i, 64'h0, 2'b00, "R2");
    access(0, 5, 64'h0, 2'b00, "R7");
    access(0, 200, 64'h0, 2'b00, "R2");
    access(0, 77, 64'h0, 2'b00, "R8");

    // bank 1 failed: single-bank sequential mode
    idle(1, 2'b10);
    access(1, 3, 64'h1111_2222_3333_4444, 2'b10, "R11");
    access(0, 3, 64'h0, 2'b10, "R4");
    access(1, 127, 64'h5555_6666_7777_8888, 2'b10, "R3");
    access(0, 127, 64'h0, 2'b10, "R4");
    access(0, 128, 64'h0, 2'b10, "R5");
    access(1, 250, 64'hffff_0000_ffff_0000, 2'b10, "R5");
    access(0, 2, 64'h0, 2'b10, "R8");

    // mask change inside the busy cycle must not take effect
    idle(1, 2'b01);
    access(1, 40, 64'habcd_0001_abcd_0002, 2'b01, "R9");
    step(0, 0, 0, 64'h0, 2'b11, "R9");
    step(1, 0, 40, 64'h0, 2'b01, "R9");
    access(0, 40, 64'h0, 2'b01, "R4");

    // every bank failed
    idle(1, 2'b11);
    access(0, 40, 64'h0, 2'b11, "R6");
    access(1, 9, 64'h9, 2'b11, "R6");

    // back to normal mode
    idle(1, 2'b00);
    access(0, 200, 64'h0, 2'b00, "R2");
    access(0, 9, 64'h0, 2'b00, "R8");

    // mixed traffic with mode changes
    for (int i = 0; i < 300; i++) begin
      logic [NB-1:0] m;
      m = (i / 40) % 3 == 0 ? 2'b00 : ((i / 40) % 3 == 1 ? 2'b01 : 2'b10);
      access(1'($urandom % 2), int'($urandom % DEP), {$urandom, $urandom}, m, "R4");
    end
    idle(4, 2'b00);
    summary();
  end
endmodule